// File: doc/BRIEF.md
# Coprocessor Handshake Sequencer

This block runs one core-side transaction against an attached coprocessor for four kinds of work: moving a word to the coprocessor, moving a word back from it, asking it to perform an internal data operation, and streaming words between it and memory in either direction. A start strobe launches a transaction. With the strobe the core gives an instruction class, the instruction word and one operand. The operand is the base address for the memory classes and the source word for a move to the coprocessor.

The sequencer opens every exchange with a first-phase request. While the coprocessor answers busy, it waits one idle cycle and then polls again. In that idle cycle a pending interrupt can cancel the transaction. For the memory classes the coprocessor decides the burst length: it answers increment for each further word it wants, and the address advances by one word each beat. A single-cycle done pulse carries the outcome: undefined instruction, abort, interrupted (with its cause), or a clean finish, plus the returned word for a move from the coprocessor.

Top module: `cop_xact_seq`

## Requirements
- R1: While reset is held, and after it is released with no start, cp_req, mem_req and done are all 0.
- R2: A start accepted in idle produces a request with phase code 1 (first) in the next cycle. A start strobe that arrives while a transaction is in progress is ignored and does not produce a second transaction.
- R3: Response code 1 (busy) to a first or busy-phase request is followed by exactly one cycle with no request, and then a request with phase code 2 (busy).
- R4: If an interrupt is pending in the idle cycle after a busy response, the next request carries phase code 3 (interrupt). No memory access follows, and done then reports interrupted.
- R5: An interrupt is pending when rst_req_n is 0 (cause 0), else when fiq=1 and fiq_mask=0 (cause 1), else when irq=1 and irq_mask=0 (cause 2), with priority in that order. Masked inputs never cancel a transaction.
- R6: Response code 2 (cannot handle) to a first or busy-phase request gives undef for classes 0 (move to), 1 (move from) and 2 (data operation). It gives abort for classes 3 (load) and 4 (store). No memory access follows in either case.
- R7: A move from the coprocessor that ends with response 0 (done) returns cp_rdata from that cycle on result. If it ends with cannot-handle, result is 0xF0000000, with the four flag bits [31:28] set.
- R8: A load reads memory at base, base+4, ... one word per beat, and passes each read word to the coprocessor on cp_wdata with phase code 4 (data). The burst continues while the response is code 3 (increment).
- R9: A store writes cp_rdata to memory at base, base+4, ... one word per beat, each with a data-phase request. The burst continues while the response is increment.
- R10: A store to an address below VEC_TOP (0x20), or any memory-class transaction whose base is not word aligned, ends with abort one cycle after start and sends no coprocessor request.
- R11: A memory error on any beat does not stop the burst. It is reported as abort in the done pulse at the end of the transaction.
- R12: A burst never exceeds 16 beats. Increment on the 16th beat ends the transaction with abort.
- R13: done is a one-cycle pulse that carries at most one of undef, abort and intr. It follows the final response by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a transaction (accepted in idle only) |
| xclass | input | 3 | Class: 0 move to, 1 move from, 2 data op, 3 load, 4 store |
| instr | input | 32 | Instruction word forwarded to the coprocessor |
| opnd | input | 32 | Base address (memory classes) or source word (move to) |
| rst_req_n | input | 1 | Core reset request, active low, highest interrupt priority |
| fiq | input | 1 | Fast interrupt request |
| fiq_mask | input | 1 | Fast interrupt mask |
| irq | input | 1 | Normal interrupt request |
| irq_mask | input | 1 | Normal interrupt mask |
| cp_req | output | 1 | Request valid to the coprocessor |
| cp_phase | output | 3 | 1 first, 2 busy, 3 interrupt, 4 data |
| cp_instr | output | 32 | Latched instruction word |
| cp_wdata | output | 32 | Word to the coprocessor |
| cp_resp | input | 2 | 0 done, 1 busy, 2 cannot handle, 3 increment (same cycle) |
| cp_rdata | input | 32 | Word from the coprocessor |
| mem_req | output | 1 | Memory beat valid |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Beat address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data (same cycle) |
| mem_err | input | 1 | Memory error for the current beat |
| done | output | 1 | Transaction finished (one cycle) |
| undef | output | 1 | Undefined instruction outcome |
| abort | output | 1 | Abort outcome |
| intr | output | 1 | Interrupted outcome |
| intr_cause | output | 2 | 0 reset, 1 fast, 2 normal |
| result | output | 32 | Word returned by a move from the coprocessor |

## Verification
Each outcome has a fixed cycle count from the start edge. The first request appears one cycle after it, and each busy response adds two cycles. Each burst beat adds one cycle, and done follows the last response by one cycle. A bad address gives done one cycle after start, and an interrupt cancel gives done four cycles after start. The bench drives the coprocessor and memory responses on the falling edge and logs every request, phase and beat shortly after. It records the cycle of done relative to the start edge and compares it with these counts.

// File: rtl/cxs_pkg.sv
package cxs_pkg;

    typedef enum logic [2:0] {
        CLS_MOVE_TO   = 3'd0,
        CLS_MOVE_FROM = 3'd1,
        CLS_DATA_OP   = 3'd2,
        CLS_LOAD      = 3'd3,
        CLS_STORE     = 3'd4
    } xclass_e;

    typedef enum logic [2:0] {
        PH_NONE  = 3'd0,
        PH_FIRST = 3'd1,
        PH_BUSY  = 3'd2,
        PH_INTR  = 3'd3,
        PH_DATA  = 3'd4
    } phase_e;

    typedef enum logic [1:0] {
        RSP_DONE = 2'd0,
        RSP_BUSY = 2'd1,
        RSP_CANT = 2'd2,
        RSP_INC  = 2'd3
    } resp_e;

    typedef enum logic [1:0] {
        IC_RESET  = 2'd0,
        IC_FAST   = 2'd1,
        IC_NORMAL = 2'd2,
        IC_NONE   = 2'd3
    } icause_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FIRST,
        ST_WAIT,
        ST_POLL,
        ST_INTR,
        ST_BEAT,
        ST_FIN
    } seq_state_e;

    typedef struct packed {
        logic undef;
        logic abort;
        logic intr;
    } status_t;

    localparam int FLAG_BITS = 4;

    function automatic logic is_mem_class(input logic [2:0] c);
        return (c == CLS_LOAD) || (c == CLS_STORE);
    endfunction

    function automatic logic [31:0] forced_flags32();
        logic [31:0] v;
        v = '0;
        v[31 -: FLAG_BITS] = '1;
        return v;
    endfunction

endpackage

// File: rtl/cxs_irq_arb.sv
module cxs_irq_arb
    import cxs_pkg::*;
(
    input  logic    rst_req_n,
    input  logic    fiq,
    input  logic    fiq_mask,
    input  logic    irq,
    input  logic    irq_mask,
    output logic    pending,
    output icause_e cause
);
    logic [2:0] req_vec;

    assign req_vec = {irq & ~irq_mask, fiq & ~fiq_mask, ~rst_req_n};

    always_comb begin
        cause = IC_NONE;
        if (req_vec[0])      cause = IC_RESET;
        else if (req_vec[1]) cause = IC_FAST;
        else if (req_vec[2]) cause = IC_NORMAL;
    end

    assign pending = |req_vec;

    always_comb begin
        if (pending) begin
            a_r5_cause_valid : assert (cause != IC_NONE);
        end
    end
endmodule

// File: rtl/cxs_addr_chk.sv
module cxs_addr_chk #(
    parameter int          ADDR_W     = 32,
    parameter int          ALIGN_BITS = 2,
    parameter logic [31:0] VEC_TOP    = 32'h20
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_mem,
    input  logic              is_store,
    output logic              bad
);
    logic misaligned;
    logic in_vectors;

    generate
        if (ALIGN_BITS > 0) begin : g_align
            assign misaligned = |addr[ALIGN_BITS-1:0];
        end else begin : g_noalign
            assign misaligned = 1'b0;
        end
    endgenerate

    assign in_vectors = (addr < ADDR_W'(VEC_TOP));
    assign bad = is_mem && (misaligned || (is_store && in_vectors));
endmodule

// File: rtl/cxs_burst.sv
module cxs_burst #(
    parameter int ADDR_W    = 32,
    parameter int MAX_BEATS = 16,
    parameter int STEP      = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              at_cap
);
    localparam int CNT_W = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MAX_BEATS - 1);

    logic [CNT_W-1:0] beat_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr     <= '0;
            beat_idx <= '0;
        end else if (load) begin
            addr     <= base;
            beat_idx <= '0;
        end else if (step && !at_cap) begin
            addr     <= addr + ADDR_W'(STEP);
            beat_idx <= beat_idx + 1'b1;
        end
    end

    assign at_cap = (beat_idx == LAST);

    a_r12_beat_bound : assert property (@(posedge clk) disable iff (rst)
        (step && at_cap && !load) |=> $stable(beat_idx));
endmodule

// File: rtl/cop_xact_seq.sv
module cop_xact_seq
    import cxs_pkg::*;
#(
    parameter int          DATA_W    = 32,
    parameter int          ADDR_W    = 32,
    parameter int          MAX_BEATS = 16,
    parameter logic [31:0] VEC_TOP   = 32'h20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        xclass,
    input  logic [31:0]       instr,
    input  logic [DATA_W-1:0] opnd,
    input  logic              rst_req_n,
    input  logic              fiq,
    input  logic              fiq_mask,
    input  logic              irq,
    input  logic              irq_mask,
    output logic              cp_req,
    output logic [2:0]        cp_phase,
    output logic [31:0]       cp_instr,
    output logic [DATA_W-1:0] cp_wdata,
    input  logic [1:0]        cp_resp,
    input  logic [DATA_W-1:0] cp_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_err,
    output logic              done,
    output logic              undef,
    output logic              abort,
    output logic              intr,
    output logic [1:0]        intr_cause,
    output logic [DATA_W-1:0] result
);
    localparam int BYTES      = DATA_W / 8;
    localparam int ALIGN_BITS = $clog2(BYTES);

    seq_state_e        state;
    logic [2:0]        cls_q;
    logic [31:0]       instr_q;
    logic [DATA_W-1:0] opnd_q;
    status_t           stat_q;
    logic [DATA_W-1:0] result_q;
    icause_e           cause_q;
    logic              memerr_q;

    logic              irq_pend;
    icause_e           irq_cause;
    logic              addr_bad;
    logic              burst_load;
    logic              burst_step;
    logic              burst_cap;
    logic [ADDR_W-1:0] burst_addr;
    phase_e            phase;
    resp_e             rsp;
    logic              cls_mem;
    logic              cls_store;

    assign rsp       = resp_e'(cp_resp);
    assign cls_mem   = is_mem_class(cls_q);
    assign cls_store = (cls_q == CLS_STORE);

    cxs_irq_arb u_arb (
        .rst_req_n (rst_req_n),
        .fiq       (fiq),
        .fiq_mask  (fiq_mask),
        .irq       (irq),
        .irq_mask  (irq_mask),
        .pending   (irq_pend),
        .cause     (irq_cause)
    );

    cxs_addr_chk #(
        .ADDR_W     (ADDR_W),
        .ALIGN_BITS (ALIGN_BITS),
        .VEC_TOP    (VEC_TOP)
    ) u_chk (
        .addr     (opnd[ADDR_W-1:0]),
        .is_mem   (is_mem_class(xclass)),
        .is_store (xclass == CLS_STORE),
        .bad      (addr_bad)
    );

    assign burst_load = (state == ST_IDLE) && start;
    assign burst_step = (state == ST_BEAT) && (rsp == RSP_INC);

    cxs_burst #(
        .ADDR_W    (ADDR_W),
        .MAX_BEATS (MAX_BEATS),
        .STEP      (BYTES)
    ) u_burst (
        .clk    (clk),
        .rst    (rst),
        .load   (burst_load),
        .base   (opnd[ADDR_W-1:0]),
        .step   (burst_step),
        .addr   (burst_addr),
        .at_cap (burst_cap)
    );

    // Sequencing
    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cls_q    <= '0;
            instr_q  <= '0;
            opnd_q   <= '0;
            stat_q   <= '0;
            result_q <= '0;
            cause_q  <= IC_NONE;
            memerr_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        cls_q    <= xclass;
                        instr_q  <= instr;
                        opnd_q   <= opnd;
                        result_q <= '0;
                        cause_q  <= IC_NONE;
                        memerr_q <= 1'b0;
                        stat_q   <= '0;
                        if (addr_bad) begin
                            stat_q.abort <= 1'b1;
                            state        <= ST_FIN;
                        end else begin
                            state <= ST_FIRST;
                        end
                    end
                end
                ST_FIRST, ST_POLL: begin
                    case (rsp)
                        RSP_BUSY: state <= ST_WAIT;
                        RSP_CANT: begin
                            if (cls_mem) stat_q.abort <= 1'b1;
                            else         stat_q.undef <= 1'b1;
                            if (cls_q == CLS_MOVE_FROM)
                                result_q <= DATA_W'(forced_flags32());
                            state <= ST_FIN;
                        end
                        default: begin
                            if (cls_mem) begin
                                state <= ST_BEAT;
                            end else begin
                                if (cls_q == CLS_MOVE_FROM) result_q <= cp_rdata;
                                state <= ST_FIN;
                            end
                        end
                    endcase
                end
                ST_WAIT: begin
                    if (irq_pend) begin
                        cause_q <= irq_cause;
                        state   <= ST_INTR;
                    end else begin
                        state <= ST_POLL;
                    end
                end
                ST_INTR: begin
                    stat_q.intr <= 1'b1;
                    state       <= ST_FIN;
                end
                ST_BEAT: begin
                    memerr_q <= memerr_q | mem_err;
                    if (rsp == RSP_INC) begin
                        if (burst_cap) begin
                            stat_q.abort <= 1'b1;
                            state        <= ST_FIN;
                        end
                    end else begin
                        stat_q.abort <= memerr_q | mem_err | (rsp == RSP_CANT);
                        state        <= ST_FIN;
                    end
                end
                ST_FIN:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Request side
    always_comb begin
        case (state)
            ST_FIRST: phase = PH_FIRST;
            ST_POLL:  phase = PH_BUSY;
            ST_INTR:  phase = PH_INTR;
            ST_BEAT:  phase = PH_DATA;
            default:  phase = PH_NONE;
        endcase
    end

    assign cp_req   = (phase != PH_NONE);
    assign cp_phase = phase;
    assign cp_instr = instr_q;

    always_comb begin
        cp_wdata = '0;
        if ((state == ST_FIRST || state == ST_POLL) && cls_q == CLS_MOVE_TO)
            cp_wdata = opnd_q;
        else if (state == ST_BEAT && !cls_store)
            cp_wdata = mem_rdata;
    end

    assign mem_req   = (state == ST_BEAT);
    assign mem_we    = mem_req && cls_store;
    assign mem_addr  = mem_req ? burst_addr : '0;
    assign mem_wdata = mem_we ? cp_rdata : '0;

    // Completion side
    assign done       = (state == ST_FIN);
    assign undef      = done && stat_q.undef;
    assign abort      = done && stat_q.abort;
    assign intr       = done && stat_q.intr;
    assign intr_cause = (done && stat_q.intr) ? cause_q : 2'd0;
    assign result     = done ? result_q : '0;

    a_r2_first_after_start : assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && start && !addr_bad) |=> (cp_req && cp_phase == PH_FIRST));

    a_r3_gap_after_busy : assert property (@(posedge clk) disable iff (rst)
        (cp_req && (cp_phase == PH_FIRST || cp_phase == PH_BUSY) && cp_resp == RSP_BUSY)
        |=> (!cp_req && !done));

    a_r4_no_mem_on_intr : assert property (@(posedge clk) disable iff (rst)
        (cp_req && cp_phase == PH_INTR) |=> (done && !mem_req));

    a_r9_write_with_data : assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (cp_req && cp_phase == PH_DATA));

    a_r13_done_pulse : assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r13_one_outcome : assert property (@(posedge clk) disable iff (rst)
        done |-> ($countones({undef, abort, intr}) <= 1));
endmodule

// File: tb/tb_cop_xact_seq.sv
`timescale 1ns/1ps
module tb_cop_xact_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  xclass = '0;
    logic [31:0] instr = '0;
    logic [31:0] opnd = '0;
    logic        rst_req_n = 1'b1;
    logic        fiq = 1'b0, fiq_mask = 1'b0, irq = 1'b0, irq_mask = 1'b0;
    logic        cp_req;
    logic [2:0]  cp_phase;
    logic [31:0] cp_instr, cp_wdata;
    logic [1:0]  cp_resp = 2'd0;
    logic [31:0] cp_rdata = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_err = 1'b0;
    logic        done, undef, abort, intr;
    logic [1:0]  intr_cause;
    logic [31:0] result;

    always #2 clk = ~clk;

    cop_xact_seq dut (
        .clk(clk), .rst(rst), .start(start), .xclass(xclass), .instr(instr), .opnd(opnd),
        .rst_req_n(rst_req_n), .fiq(fiq), .fiq_mask(fiq_mask), .irq(irq), .irq_mask(irq_mask),
        .cp_req(cp_req), .cp_phase(cp_phase), .cp_instr(cp_instr), .cp_wdata(cp_wdata),
        .cp_resp(cp_resp), .cp_rdata(cp_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_err(mem_err),
        .done(done), .undef(undef), .abort(abort), .intr(intr),
        .intr_cause(intr_cause), .result(result)
    );

    int nchk = 0, nfail = 0;
    int cyc = 0, start_cyc = 0, done_at = 0;
    bit arm = 0;
    int req_cnt = 0, beat_cnt = 0, done_cnt = 0, err_beat = 99;
    logic [1:0]  resp_scr [0:39];
    logic [31:0] rd_scr   [0:39];
    logic [2:0]  ph_log   [0:39];
    logic [31:0] wd_log   [0:39];
    logic [31:0] instr_log[0:39];
    logic [31:0] ma_log   [0:39];
    logic [31:0] mw_log   [0:39];
    logic        we_log   [0:39];
    logic        f_undef, f_abort, f_intr;
    logic [1:0]  f_cause;
    logic [31:0] f_result;

    // Coprocessor and memory model: respond on the falling edge, log 1 ns later
    always @(negedge clk) begin
        cyc = cyc + 1;
        mem_rdata = '0;
        mem_err   = 1'b0;
        if (mem_req && !mem_we) mem_rdata = mem_addr ^ 32'hA5A5_0000;
        if (mem_req) mem_err = (beat_cnt == err_beat);
        if (cp_req && req_cnt < 40) begin
            cp_resp  = resp_scr[req_cnt];
            cp_rdata = rd_scr[req_cnt];
        end
        #1;
        if (start && arm) begin start_cyc = cyc; arm = 0; end
        if (cp_req) begin
            if (req_cnt < 40) begin
                ph_log[req_cnt]    = cp_phase;
                wd_log[req_cnt]    = cp_wdata;
                instr_log[req_cnt] = cp_instr;
            end
            req_cnt++;
        end
        if (mem_req) begin
            if (beat_cnt < 40) begin
                ma_log[beat_cnt] = mem_addr;
                mw_log[beat_cnt] = mem_wdata;
                we_log[beat_cnt] = mem_we;
            end
            beat_cnt++;
        end
        if (done) begin
            done_cnt++;
            done_at  = cyc - start_cyc;
            f_undef  = undef; f_abort = abort; f_intr = intr;
            f_cause  = intr_cause; f_result = result;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_script();
        for (int i = 0; i < 40; i++) begin
            resp_scr[i] = 2'd0;
            rd_scr[i]   = 32'hC0DE_0000 + i;
        end
        req_cnt = 0; beat_cnt = 0; done_cnt = 0; err_beat = 99; done_at = -1;
    endtask

    task automatic launch(input logic [2:0] c, input logic [31:0] op, input logic [31:0] iw);
        @(negedge clk);
        xclass = c; opnd = op; instr = iw; arm = 1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic finish_wait(input string tag);
        int k;
        k = 0;
        while (done_cnt == 0 && k < 80) begin @(negedge clk); k++; end
        repeat (4) @(negedge clk);
        chk({tag, " R13 single done"}, done_cnt, 1);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 cp_req in reset", cp_req, 0);
        chk("R1 mem_req in reset", mem_req, 0);
        chk("R1 done in reset", done, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 idle outputs", {cp_req, mem_req, done}, 0);
    endtask

    task automatic t_move_to();
        clear_script();
        launch(3'd0, 32'h1357_9BDF, 32'hEE00_0010);
        finish_wait("move_to");
        chk("R2 first phase", ph_log[0], 1);
        chk("R2 instr forwarded", instr_log[0], 32'hEE00_0010);
        chk("R2 source word", wd_log[0], 32'h1357_9BDF);
        chk("R13 done latency", done_at, 2);
        chk("R13 clean outcome", {f_undef, f_abort, f_intr}, 0);
    endtask

    task automatic t_move_from_busy_ignore();
        clear_script();
        resp_scr[0] = 2'd1; resp_scr[1] = 2'd1; resp_scr[2] = 2'd0;
        rd_scr[2] = 32'h1234_5678;
        launch(3'd1, 32'h0, 32'hEE10_0010);
        @(negedge clk);
        start = 1'b1; xclass = 3'd4; opnd = 32'h400;
        @(negedge clk);
        start = 1'b0;
        finish_wait("move_from");
        chk("R3 phase0", ph_log[0], 1);
        chk("R3 phase1 busy", ph_log[1], 2);
        chk("R3 phase2 busy", ph_log[2], 2);
        chk("R2 stray start ignored reqs", req_cnt, 3);
        chk("R2 stray start no mem", beat_cnt, 0);
        chk("R3 busy latency", done_at, 6);
        chk("R7 returned word", f_result, 32'h1234_5678);
    endtask

    task automatic t_cant(input logic [2:0] c, input logic [31:0] op, input bit exp_undef,
                          input logic [31:0] exp_res);
        clear_script();
        resp_scr[0] = 2'd2;
        launch(c, op, 32'hEC00_0000);
        finish_wait("cant");
        chk("R6 undef", f_undef, exp_undef);
        chk("R6 abort", f_abort, !exp_undef);
        chk("R6 no memory", beat_cnt, 0);
        chk("R7 result on cant", f_result, exp_res);
        chk("R6 latency", done_at, 2);
    endtask

    task automatic t_intr(input logic rn, input logic f, input logic fm, input logic i,
                          input logic im, input bit exp_cancel, input logic [1:0] exp_cause);
        clear_script();
        resp_scr[0] = 2'd1; resp_scr[1] = 2'd0;
        rst_req_n = rn; fiq = f; fiq_mask = fm; irq = i; irq_mask = im;
        launch(3'd3, 32'h300, 32'hED90_0000);
        finish_wait("intr");
        rst_req_n = 1'b1; fiq = 0; fiq_mask = 0; irq = 0; irq_mask = 0;
        if (exp_cancel) begin
            chk("R4 intr phase", ph_log[1], 3);
            chk("R4 no memory", beat_cnt, 0);
            chk("R4 interrupted", {f_undef, f_abort, f_intr}, 3'b001);
            chk("R4 latency", done_at, 4);
            chk("R5 cause", f_cause, exp_cause);
        end else begin
            chk("R5 masked keeps polling", ph_log[1], 2);
            chk("R5 masked not interrupted", f_intr, 0);
            chk("R5 masked reaches burst", beat_cnt, 1);
        end
    endtask

    task automatic t_load(input int nb, input int errb);
        clear_script();
        resp_scr[0] = 2'd0;
        for (int b = 1; b <= nb; b++) resp_scr[b] = (b == nb) ? 2'd0 : 2'd3;
        err_beat = errb;
        launch(3'd3, 32'h100, 32'hED90_0000);
        finish_wait("load");
        chk("R8 beats", beat_cnt, nb);
        for (int b = 0; b < nb; b++) begin
            chk("R8 address", ma_log[b], 32'h100 + 4 * b);
            chk("R8 word to coprocessor", wd_log[b+1], (32'h100 + 4 * b) ^ 32'hA5A5_0000);
            chk("R8 data phase", ph_log[b+1], 4);
        end
        chk("R8 latency", done_at, 2 + nb);
        chk("R11 abort on memory error", f_abort, (errb < nb) ? 1 : 0);
    endtask

    task automatic t_store();
        clear_script();
        resp_scr[0] = 2'd1; resp_scr[1] = 2'd0; resp_scr[2] = 2'd3; resp_scr[3] = 2'd0;
        rd_scr[2] = 32'hDEAD_0001; rd_scr[3] = 32'hBEEF_0002;
        launch(3'd4, 32'h200, 32'hED80_0000);
        finish_wait("store");
        chk("R9 beats", beat_cnt, 2);
        chk("R9 write enable", we_log[0] & we_log[1], 1);
        chk("R9 addr0", ma_log[0], 32'h200);
        chk("R9 addr1", ma_log[1], 32'h204);
        chk("R9 data0", mw_log[0], 32'hDEAD_0001);
        chk("R9 data1", mw_log[1], 32'hBEEF_0002);
        chk("R9 latency", done_at, 6);
        chk("R9 clean", f_abort, 0);
    endtask

    task automatic t_bad_addr(input logic [2:0] c, input logic [31:0] op);
        clear_script();
        launch(c, op, 32'hED80_0000);
        finish_wait("bad_addr");
        chk("R10 abort", f_abort, 1);
        chk("R10 no coprocessor request", req_cnt, 0);
        chk("R10 latency", done_at, 1);
    endtask

    task automatic t_cap();
        clear_script();
        for (int i = 1; i < 40; i++) resp_scr[i] = 2'd3;
        launch(3'd3, 32'h1000, 32'hED90_0000);
        finish_wait("cap");
        chk("R12 beats capped", beat_cnt, 16);
        chk("R12 abort", f_abort, 1);
        chk("R12 last address", ma_log[15], 32'h1000 + 60);
        chk("R12 latency", done_at, 18);
    endtask

    initial begin
        t_reset();
        t_move_to();
        t_move_from_busy_ignore();
        t_cant(3'd2, 32'h0, 1'b1, 32'h0);
        t_cant(3'd1, 32'h0, 1'b1, 32'hF000_0000);
        t_cant(3'd3, 32'h100, 1'b0, 32'h0);
        t_intr(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1);
        t_intr(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0);
        t_intr(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 2'd2);
        t_intr(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0);
        t_load(3, 99);
        t_load(1, 99);
        t_load(3, 1);
        t_store();
        t_bad_addr(3'd4, 32'h10);
        t_bad_addr(3'd3, 32'h102);
        t_cap();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        nchk++; nfail++;
        $display("FAIL watchdog R13 actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule